// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This controller gathers twenty-two level-sensitive interrupt lines from on-chip peripherals and one encoded external request. It picks the single highest-priority request and presents its priority level and a fixed event vector code to the processor. Priority is not set per line. Each peripheral group owns a 4-bit field in one of three 16-bit priority registers, and every line in that group shares the field. A 32-bit mask register can knock out individual lines. It is written through two separate addresses: one sets mask bits and one clears them.

The processor supplies its current interrupt mask level. The controller raises its request output only while the winning level is strictly above that mask level. Requests are never cleared here: each peripheral holds its line until software services it at the source. Software programs the block through a simple word-addressed register bus with a one-cycle registered read path.

Top module: `vic_top`

## Requirements
- R1: After reset all priority fields and all mask bits are zero, irqReq, irqLevel and irqVector are zero, and every register reads back as zero.
- R2: Bus word addresses are 0, 1 and 2 for priority registers A, B and C, and 3 for a read of the mask. Within each priority register the slot in bits [15:12] comes first, then [11:8], [7:4] and [3:0]. Slots of A are timer0, timer1, timer2, clock. Slots of B are watchdog, refresh, serial, unused. Slots of C are gpio, dma, fifo-serial, debug.
- R3: Source indices and fixed vectors: 0 timer0 0x400, 1 timer1 0x420, 2 timer2 underflow 0x440, 3 timer2 capture 0x460, 4-6 clock 0x480/0x4A0/0x4C0, 7-10 serial 0x4E0/0x500/0x520/0x540, 11 watchdog 0x560, 12-13 refresh 0x580/0x5A0, 14 debug 0x600, 15 gpio 0x620, 16 dma end 0x640, 17 dma error 0x6C0, 18-21 fifo-serial 0x700/0x720/0x740/0x760. Every vector is a multiple of 0x20.
- R4: All sources of one group take their level from the group's shared field.
- R5: A field value of 0 disables its sources. Among enabled sources the larger level wins. With no enabled request, irqLevel and irqVector are 0.
- R6: Between internal sources of equal level, the lower source index wins.
- R7: extLevel n in 0..14 requests at level 15-n with vector 0x200+0x20*n, and extLevel 15 means no request. The external request wins ties against internal sources and is not affected by the mask register.
- R8: Mask bit i (1 = masked) removes source i from arbitration. A write to address 4 sets the mask bits that are 1 in the data, and a write to address 5 clears them. Bits at or above 22 always read 0.
- R9: irqReq is 1 exactly when the winning level is strictly greater than cpuMask. irqLevel and irqVector show the winner regardless of cpuMask.
- R10: Bits [31:16] of a priority write are ignored, and slot [3:0] of register B always reads 0.
- R11: Outputs are registered. A change on srcPending, extLevel or cpuMask shows on the outputs after the next rising edge and not before. A register write affects the outputs one edge later than it does the register contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after a read |
| srcPending | input | 22 | Level-sensitive internal requests |
| extLevel | input | 4 | Encoded external request, 15 = idle |
| cpuMask | input | 4 | Processor's current mask level |
| irqReq | output | 1 | Request to the processor |
| irqLevel | output | 4 | Level of the winning request |
| irqVector | output | 12 | Vector code of the winning request |

## Verification
A change on a request input or on cpuMask is due on the outputs after one rising edge. A priority or mask write needs two edges: one to load the register and one to re-arbitrate. Read data is due after the single edge that captures it. The driver waits two rising edges after each stimulus before it queues an expectation, so both latencies have settled. The monitor compares the outputs on the following falling edge, away from any edge that moves them. One separate check samples the outputs just after an input change and before the next rising edge, to confirm that nothing moves early.

// File: rtl/vic_pkg.sv
package vic_pkg;

  localparam int NUM_SRC      = 22;
  localparam int NUM_PRIO     = 3;
  localparam int SLOTS        = 4;
  localparam int LVL_W        = 4;
  localparam int VEC_W        = 12;
  localparam int REG_W        = SLOTS * LVL_W;
  localparam int FLAT_W       = NUM_PRIO * REG_W;
  localparam int UNUSED_FIELD = 7;
  localparam int ADDR_W       = 3;
  localparam int DATA_W       = 32;

  localparam logic [ADDR_W-1:0] ADDR_MASK = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_SET  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_CLR  = 3'd5;

  localparam logic [LVL_W-1:0] EXT_IDLE = 4'hF;
  localparam logic [VEC_W-1:0] EXT_BASE = 12'h200;

  typedef struct packed {
    logic [NUM_PRIO-1:0] prioWr;
    logic                maskSet;
    logic                maskClr;
    logic                rdEn;
    logic [ADDR_W-1:0]   rdSel;
  } vicStrobe_t;

  function automatic logic [VEC_W-1:0] srcVector(input int idx);
    case (idx)
      0:  return 12'h400;  1:  return 12'h420;  2:  return 12'h440;
      3:  return 12'h460;  4:  return 12'h480;  5:  return 12'h4A0;
      6:  return 12'h4C0;  7:  return 12'h4E0;  8:  return 12'h500;
      9:  return 12'h520;  10: return 12'h540;  11: return 12'h560;
      12: return 12'h580;  13: return 12'h5A0;  14: return 12'h600;
      15: return 12'h620;  16: return 12'h640;  17: return 12'h6C0;
      18: return 12'h700;  19: return 12'h720;  20: return 12'h740;
      default: return 12'h760;
    endcase
  endfunction

  // Field id = register * SLOTS + slot, slot 0 being the top nibble.
  function automatic int srcField(input int idx);
    case (idx)
      0: return 0;
      1: return 1;
      2, 3: return 2;
      4, 5, 6: return 3;
      7, 8, 9, 10: return 6;
      11: return 4;
      12, 13: return 5;
      14: return 11;
      15: return 8;
      16, 17: return 9;
      default: return 10;
    endcase
  endfunction

  function automatic int fieldLsb(input int f);
    return (f / SLOTS) * REG_W + (SLOTS - 1 - (f % SLOTS)) * LVL_W;
  endfunction

  function automatic logic [REG_W-1:0] regKeep(input int r);
    logic [REG_W-1:0] k;
    k = '1;
    for (int s = 0; s < SLOTS; s++)
      if (r * SLOTS + s == UNUSED_FIELD) k[(SLOTS-1-s)*LVL_W +: LVL_W] = '0;
    return k;
  endfunction

endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
(
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output vicStrobe_t        strobe
);

  logic wrAcc;
  assign wrAcc = busSel & busWrite;

  genvar r;
  generate
    for (r = 0; r < NUM_PRIO; r++) begin : g_prioDec
      assign strobe.prioWr[r] = wrAcc && (busAddr == ADDR_W'(r));
    end
  endgenerate

  assign strobe.maskSet = wrAcc && (busAddr == ADDR_SET);
  assign strobe.maskClr = wrAcc && (busAddr == ADDR_CLR);
  assign strobe.rdEn    = busSel & ~busWrite;
  assign strobe.rdSel   = busAddr;

endmodule

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  vicStrobe_t         strobe,
  input  logic [DATA_W-1:0]  wdata,
  output logic [FLAT_W-1:0]  prioFlat,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [DATA_W-1:0]  rdata
);

  logic [REG_W-1:0] prioQ [NUM_PRIO];

  genvar r;
  generate
    for (r = 0; r < NUM_PRIO; r++) begin : g_prio
      localparam logic [REG_W-1:0] KEEP = regKeep(r);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 prioQ[r] <= '0;
        else if (strobe.prioWr[r]) prioQ[r] <= wdata[REG_W-1:0] & KEEP;
      end
      assign prioFlat[r*REG_W +: REG_W] = prioQ[r];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               maskQ <= '0;
    else if (strobe.maskSet) maskQ <= maskQ | wdata[NUM_SRC-1:0];
    else if (strobe.maskClr) maskQ <= maskQ & ~wdata[NUM_SRC-1:0];
  end

  logic [DATA_W-1:0] rdNext;
  always_comb begin
    rdNext = '0;
    if (strobe.rdSel == ADDR_MASK) rdNext = DATA_W'(maskQ);
    else if (int'(strobe.rdSel) < NUM_PRIO)
      rdNext = DATA_W'(prioFlat[int'(strobe.rdSel)*REG_W +: REG_W]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdata <= '0;
    else if (strobe.rdEn) rdata <= rdNext;
  end

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.maskSet |=> ((maskQ & $past(wdata[NUM_SRC-1:0])) == $past(wdata[NUM_SRC-1:0]))); // R8
  AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.maskClr |=> ((maskQ & $past(wdata[NUM_SRC-1:0])) == '0)); // R8
  AST_UNUSED_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && strobe.rdSel == 3'd1) |=> (rdata[3:0] == 4'h0)); // R10
  AST_PRIO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.prioWr == '0) |=> $stable(prioFlat)); // R2

endmodule

// File: rtl/vic_arb.sv
module vic_arb
  import vic_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [FLAT_W-1:0]  prioFlat,
  input  logic [NUM_SRC-1:0] maskQ,
  input  logic [NUM_SRC-1:0] srcPending,
  input  logic [LVL_W-1:0]   extLevel,
  input  logic [LVL_W-1:0]   cpuMask,
  output logic               irqReq,
  output logic [LVL_W-1:0]   irqLevel,
  output logic [VEC_W-1:0]   irqVector
);

  logic [LVL_W-1:0] srcLvl [NUM_SRC];
  logic [VEC_W-1:0] srcVec [NUM_SRC];

  genvar i;
  generate
    for (i = 0; i < NUM_SRC; i++) begin : g_src
      localparam int LSB = fieldLsb(srcField(i));
      assign srcLvl[i] = (srcPending[i] && !maskQ[i]) ? prioFlat[LSB +: LVL_W] : '0;
      assign srcVec[i] = srcVector(i);
    end
  endgenerate

  logic [LVL_W-1:0] bestLvl;
  logic [VEC_W-1:0] bestVec;

  always_comb begin
    if (extLevel != EXT_IDLE) begin
      bestLvl = EXT_IDLE - extLevel;
      bestVec = EXT_BASE + VEC_W'({extLevel, 5'b0});
    end else begin
      bestLvl = '0;
      bestVec = '0;
    end
    for (int k = 0; k < NUM_SRC; k++) begin
      if (srcLvl[k] > bestLvl) begin
        bestLvl = srcLvl[k];
        bestVec = srcVec[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReq    <= 1'b0;
      irqLevel  <= '0;
      irqVector <= '0;
    end else begin
      irqReq    <= bestLvl > cpuMask;
      irqLevel  <= bestLvl;
      irqVector <= bestVec;
    end
  end

  AST_REQ_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqLevel > $past(cpuMask))); // R9
  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel != '0) |-> (irqVector[4:0] == 5'b0 && irqVector != '0)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (extLevel == EXT_IDLE && srcPending == '0) |=> (!irqReq && irqLevel == '0 && irqVector == '0)); // R5
  AST_EXT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (extLevel == 4'h0) |=> (irqLevel == 4'hF && irqVector == 12'h200)); // R7

endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] srcPending,
  input  logic [LVL_W-1:0]   extLevel,
  input  logic [LVL_W-1:0]   cpuMask,
  output logic               irqReq,
  output logic [LVL_W-1:0]   irqLevel,
  output logic [VEC_W-1:0]   irqVector
);

  vicStrobe_t         strobe;
  logic [FLAT_W-1:0]  prioFlat;
  logic [NUM_SRC-1:0] maskQ;

  vic_ctrl u_ctrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobe   (strobe)
  );

  vic_regs u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wdata    (busWdata),
    .prioFlat (prioFlat),
    .maskQ    (maskQ),
    .rdata    (busRdata)
  );

  vic_arb u_arb (
    .clk        (clk),
    .rstN       (rstN),
    .prioFlat   (prioFlat),
    .maskQ      (maskQ),
    .srcPending (srcPending),
    .extLevel   (extLevel),
    .cpuMask    (cpuMask),
    .irqReq     (irqReq),
    .irqLevel   (irqLevel),
    .irqVector  (irqVector)
  );

endmodule

// File: tb/sim_vic_top.sv
module sim_vic_top;
  import vic_pkg::*;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               busSel = 1'b0;
  logic               busWrite = 1'b0;
  logic [ADDR_W-1:0]  busAddr = '0;
  logic [DATA_W-1:0]  busWdata = '0;
  logic [DATA_W-1:0]  busRdata;
  logic [NUM_SRC-1:0] srcPending = '0;
  logic [LVL_W-1:0]   extLevel = 4'hF;
  logic [LVL_W-1:0]   cpuMask = 4'h0;
  logic               irqReq;
  logic [LVL_W-1:0]   irqLevel;
  logic [VEC_W-1:0]   irqVector;

  always #2 clk = ~clk;

  vic_top u0 (.*);

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  function automatic logic [31:0] pk(input logic r, input logic [3:0] l, input logic [11:0] v);
    return {15'b0, r, l, v};
  endfunction

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = (it.kind == 0) ? pk(irqReq, irqLevel, irqVector) : busRdata;
      nChecks++;
      if (act !== it.exp) begin
        nFails++;
        $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expectOut(input logic r, input logic [3:0] l, input logic [11:0] v, input string tag);
    item_t it;
    repeat (2) @(posedge clk);
    #1;
    it.kind = 0; it.exp = pk(r, l, v); it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    @(posedge clk);
    #1;
    it.kind = 1; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expectOut(1'b0, 4'h0, 12'h000, "R1 outputs after reset");
    readReg(3'd0, 32'h0, "R1 prio A reset");
    readReg(3'd1, 32'h0, "R1 prio B reset");
    readReg(3'd2, 32'h0, "R1 prio C reset");
    readReg(3'd3, 32'h0, "R1 mask reset");

    srcPending = NUM_SRC'(1) << 0;
    expectOut(1'b0, 4'h0, 12'h000, "R5 zero field disables");
    writeReg(3'd0, 32'h0000_5000);
    expectOut(1'b1, 4'h5, 12'h400, "R2 R3 timer0 slot");
    writeReg(3'd0, 32'h0000_5730);
    srcPending = (NUM_SRC'(1) << 0) | (NUM_SRC'(1) << 1);
    expectOut(1'b1, 4'h7, 12'h420, "R5 higher level wins");
    srcPending = NUM_SRC'(1) << 3;
    expectOut(1'b1, 4'h3, 12'h460, "R4 capture shares timer2 field");
    srcPending = (NUM_SRC'(1) << 2) | (NUM_SRC'(1) << 3);
    expectOut(1'b1, 4'h3, 12'h440, "R6 tie in group lower index");
    writeReg(3'd1, 32'h0000_7000);
    srcPending = (NUM_SRC'(1) << 1) | (NUM_SRC'(1) << 11);
    expectOut(1'b1, 4'h7, 12'h420, "R6 tie across groups");

    writeReg(3'd4, 32'h0000_0002);
    expectOut(1'b1, 4'h7, 12'h560, "R8 masked source skipped");
    readReg(3'd3, 32'h0000_0002, "R8 mask after set");
    writeReg(3'd5, 32'h0000_0002);
    expectOut(1'b1, 4'h7, 12'h420, "R8 unmask restores");
    readReg(3'd3, 32'h0, "R8 mask after clear");

    cpuMask = 4'h7;
    expectOut(1'b0, 4'h7, 12'h420, "R9 level equal to mask");
    cpuMask = 4'h6;
    expectOut(1'b1, 4'h7, 12'h420, "R9 level above mask");
    cpuMask = 4'h0;

    extLevel = 4'h8;
    expectOut(1'b1, 4'h7, 12'h300, "R7 external wins tie");
    extLevel = 4'hE;
    expectOut(1'b1, 4'h7, 12'h420, "R7 internal beats low external");
    writeReg(3'd4, 32'hFFFF_FFFF);
    readReg(3'd3, 32'h003F_FFFF, "R8 mask width");
    extLevel = 4'h0;
    expectOut(1'b1, 4'hF, 12'h200, "R7 external ignores mask");
    extLevel = 4'hF;
    expectOut(1'b0, 4'h0, 12'h000, "R8 all masked idle");
    writeReg(3'd5, 32'hFFFF_FFFF);

    writeReg(3'd1, 32'hFFFF_FFFF);
    readReg(3'd1, 32'h0000_FFF0, "R10 unused slot");
    writeReg(3'd0, 32'hABCD_5000);
    readReg(3'd0, 32'h0000_5000, "R10 upper bits ignored");
    writeReg(3'd2, 32'h0000_F000);
    srcPending = NUM_SRC'(1) << 15;
    expectOut(1'b1, 4'hF, 12'h620, "R2 gpio slot of C");

    srcPending = '0;
    #1;
    nChecks++;
    if (pk(irqReq, irqLevel, irqVector) !== pk(1'b1, 4'hF, 12'h620)) begin
      nFails++;
      $display("FAIL R11 early change: actual 0x%08h expected 0x%08h",
               pk(irqReq, irqLevel, irqVector), pk(1'b1, 4'hF, 12'h620));
    end
    expectOut(1'b0, 4'h0, 12'h000, "R11 update after edge");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule